// File: doc/BRIEF.md
# Compare-Value Deadline Timer

This block is one timer channel. A free-running 64-bit counter advances by one on every cycle in which a tick-enable input is high. Software sets a single deadline for that counter. It can write the deadline as an absolute 64-bit compare value. It can also write it as a signed 32-bit offset from the live count. Both register views read back the same stored deadline.

A three-bit control word holds an enable flag, a mask flag and a read-only "deadline reached" flag. The block drives a level interrupt that is high while the channel is enabled, the deadline has been reached and the mask is clear. A mask hides the interrupt without hiding the reached flag, so software can poll a masked timer.

Access goes through a single-cycle register port. A 2-bit select picks one of four views: the absolute deadline, the relative deadline, the control word, or the live counter (read only). Read data is combinational on the select.

Top module: `deadline_timer`

## Requirements
- R1: The counter resets to 0, increments by exactly 1 on each clock edge where `tick_en` is high, and holds otherwise; it reads back with select 3, and writes to select 3 are ignored.
- R2: A write with select 0 loads the full 64-bit `wdata` as the deadline; it reads back with select 0 after the write edge, and the deadline never changes without a write to select 0 or 1.
- R3: A write with select 1 loads the deadline with the counter value seen at the write edge plus `wdata[31:0]` sign-extended to 64 bits.
- R4: A read with select 1 returns bits 31:0 of (deadline − counter), sign-extended to 64 bits, so the value is negative once the deadline has passed.
- R5: The control word (select 2) has the enable at bit 0, the mask at bit 1 and the reached flag at bit 2. All other bits read 0. A write changes only bits 0 and 1.
- R6: The reached flag reads 1 exactly when the enable is 1 and counter ≥ deadline (unsigned). It reads 0 while the enable is 0, and written values of bit 2 are ignored.
- R7: `irq` is a registered level. After each clock edge it equals (enable AND reached AND NOT mask) as evaluated just before that edge.
- R8: If the channel is enabled and a deadline already below the counter is written, `irq` is high two edges after the write, even while `tick_en` stays low.
- R9: Writing 0 to the control word drives `irq` low from the second edge after the write onward.
- R10: With both enable and mask set, `irq` stays low while the reached flag still reads 1; clearing the mask brings `irq` back.
- R11: After reset the deadline, the control word, the counter and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | View select: 0 absolute deadline, 1 relative deadline, 2 control, 3 counter |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for the selected view |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a deadline that is already in the past at the moment it is written, with the counter frozen. This shows that the interrupt does not wait for a counter tick. The bench reaches it with a negative relative write while `tick_en` is low, and with an absolute write below the count. It then switches the mask on and off in that expired state and confirms that the reached flag stays visible. A long random phase mixes small signed relative offsets around the live count with control writes. A behavioural model checks the output against the deadline crossings on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_ABS = 2'd0,
    SEL_REL = 2'd1,
    SEL_CTL = 2'd2,
    SEL_CNT = 2'd3
  } tmr_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_en) cnt <= cnt_d;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             en,
  input  logic             mask,
  output logic             status,
  output logic             irq
);
  logic hit;
  logic irq_d;

  always_comb begin
    hit    = (cnt >= cmp);
    status = en & hit;
    irq_d  = status & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R6
  status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !status);

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);

  // R10
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(status));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmr_sel_e         sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             status,
  output logic [CNT_W-1:0] cmp,
  output logic             en,
  output logic             mask,
  output logic [CNT_W-1:0] rdata
);
  localparam int EXT_W = CNT_W - REL_W;

  logic             cmp_we;
  logic             ctl_we;
  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] wr_off;
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] gap_ext;
  logic [CNT_W-1:0] ctl_view;

  always_comb begin
    wr_off  = {{EXT_W{wdata[REL_W-1]}}, wdata[REL_W-1:0]};
    cmp_we  = wr_en && ((sel == SEL_ABS) || (sel == SEL_REL));
    ctl_we  = wr_en && (sel == SEL_CTL);
    cmp_d   = (sel == SEL_REL) ? (cnt + wr_off) : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp <= '0;
    else if (cmp_we) cmp <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mask <= 1'b0;
    end else if (ctl_we) begin
      en   <= wdata[CTL_EN_BIT];
      mask <= wdata[CTL_MASK_BIT];
    end
  end

  always_comb begin
    gap                    = cmp - cnt;
    gap_ext                = {{EXT_W{gap[REL_W-1]}}, gap[REL_W-1:0]};
    ctl_view               = '0;
    ctl_view[CTL_EN_BIT]   = en;
    ctl_view[CTL_MASK_BIT] = mask;
    ctl_view[CTL_STAT_BIT] = status;
    case (sel)
      SEL_ABS: rdata = cmp;
      SEL_REL: rdata = gap_ext;
      SEL_CTL: rdata = ctl_view;
      default: rdata = cnt;
    endcase
  end

  // R2
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (sel == SEL_ABS || sel == SEL_REL)) |=> $stable(cmp));

  // R5
  ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CTL) |-> (rdata[CNT_W-1:CTL_STAT_BIT+1] == '0));

  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_CTL) |=> ($stable(en) && $stable(mask)));
endmodule

// File: rtl/deadline_timer.sv
module deadline_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_int_n;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic              en;
  logic              mask;
  logic              status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end

  assign rst_int_n = rst_sync[SYNC_N-1];

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .cnt     (cnt)
  );

  tmr_regs #(.CNT_W(CNT_W), .REL_W(REL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .sel    (tmr_sel_e'(sel)),
    .wdata  (wdata),
    .cnt    (cnt),
    .status (status),
    .cmp    (cmp),
    .en     (en),
    .mask   (mask),
    .rdata  (rdata)
  );

  tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cnt    (cnt),
    .cmp    (cmp),
    .en     (en),
    .mask   (mask),
    .status (status),
    .irq    (irq)
  );
endmodule

// File: tb/deadline_timer_bench.sv
`timescale 1ns/1ps
module deadline_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [1:0]  sel;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        irq;

  int n_chk;
  int n_err;
  bit done;

  longint unsigned m_cnt;
  longint unsigned m_cmp;
  bit m_en, m_mask, m_irq;

  deadline_timer u_deadline_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .sel(sel), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] m_read(bit [1:0] s);
    logic [63:0] d;
    case (s)
      2'd0: return m_cmp;
      2'd1: begin d = m_cmp - m_cnt; return {{32{d[31]}}, d[31:0]}; end
      2'd2: return {61'b0, (m_en && (m_cnt >= m_cmp)), m_mask, m_en};
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit wr, bit [1:0] s, logic [63:0] d, bit tk);
    bit nirq;
    logic [63:0] off;
    wr_en = wr; sel = s; wdata = d; tick_en = tk;
    @(posedge clk);
    nirq = m_en && !m_mask && (m_cnt >= m_cmp);
    off  = {{32{d[31]}}, d[31:0]};
    if (wr) begin
      case (s)
        2'd0: m_cmp = d;
        2'd1: m_cmp = m_cnt + off;
        2'd2: begin m_en = d[0]; m_mask = d[1]; end
        default: ;
      endcase
    end
    if (tk) m_cnt = m_cnt + 1;
    m_irq = nirq;
    @(negedge clk);
    chk("R7 irq level", {63'b0, irq}, {63'b0, m_irq});
    case (s)
      2'd0: chk("R2 deadline read", rdata, m_read(s));
      2'd1: chk("R4 relative read", rdata, m_read(s));
      2'd2: chk("R5 control read", rdata, m_read(s));
      default: chk("R1 counter read", rdata, m_read(s));
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-reqs got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    m_cnt = 0; m_cmp = 0; m_en = 0; m_mask = 0; m_irq = 0;
    rst_n = 1'b0; tick_en = 0; wr_en = 0; sel = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(0, 2'd0, 64'd0, 0);

    // R11 reset values on every view
    for (int s = 0; s < 4; s++) begin
      cyc(0, 2'(s), 64'd0, 0);
      chk("R11 reset view", rdata, 64'd0);
    end
    chk("R11 reset irq", {63'b0, irq}, 64'd0);

    // R1 counting and holding
    for (int i = 0; i < 10; i++) cyc(0, 2'd3, 64'd0, 1);
    chk("R1 count after ten ticks", rdata, 64'd10);
    cyc(1, 2'd3, 64'd999, 0);
    chk("R1 hold and write ignored", rdata, 64'd10);

    // R2 absolute deadline
    cyc(1, 2'd0, 64'd30, 0);
    chk("R2 absolute load", rdata, 64'd30);
    cyc(1, 2'd2, 64'd1, 0);
    chk("R6 enabled not yet reached", rdata, 64'd1);

    // R6/R7 crossing with ticking counter
    for (int i = 1; i <= 25; i++) begin
      cyc(0, 2'd2, 64'd0, 1);
      chk("R6 reached flag never early", {63'b0, rdata[2]}, {63'b0, (10 + i >= 30)});
      chk("R7 irq one edge after reach", {63'b0, irq}, {63'b0, (10 + i - 1 >= 30)});
    end

    // R4 negative relative after deadline (cnt 35, deadline 30)
    cyc(0, 2'd1, 64'd0, 0);
    chk("R4 relative negative", rdata, 64'hFFFF_FFFF_FFFF_FFFB);

    // R9 disable
    cyc(1, 2'd2, 64'd0, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R9 irq low after disable", {63'b0, irq}, 64'd0);
    chk("R9 flag low when disabled", rdata, 64'd0);

    // R6 writes of the flag bit ignored
    cyc(1, 2'd2, 64'd4, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R6 flag write ignored", rdata, 64'd0);
    chk("R6 irq stays low", {63'b0, irq}, 64'd0);

    // R3 relative write positive
    cyc(1, 2'd1, 64'd100, 0);
    cyc(0, 2'd0, 64'd0, 0);
    chk("R3 relative load +100", rdata, 64'd135);
    cyc(1, 2'd2, 64'd1, 0);
    cyc(0, 2'd1, 64'd0, 0);
    chk("R4 relative read +100", rdata, 64'd100);

    // R3/R8 negative relative write with frozen counter
    cyc(1, 2'd1, 64'h0000_0000_FFFF_FFF6, 0);
    chk("R8 irq not yet after write edge", {63'b0, irq}, 64'd0);
    cyc(0, 2'd0, 64'd0, 0);
    chk("R3 relative load -10", rdata, 64'd25);
    chk("R8 immediate fire without tick", {63'b0, irq}, 64'd1);

    // R10 mask
    cyc(1, 2'd2, 64'd3, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R10 masked irq low", {63'b0, irq}, 64'd0);
    chk("R10 flag visible under mask", rdata, 64'd7);
    cyc(1, 2'd2, 64'd1, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R10 unmask restores irq", {63'b0, irq}, 64'd1);

    // R2 far deadline clears condition
    cyc(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R2 far deadline irq low", {63'b0, irq}, 64'd0);
    chk("R2 far deadline flag low", rdata, 64'd1);

    // R5 upper control bits ignored
    cyc(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF8, 0);
    cyc(0, 2'd2, 64'd0, 0);
    chk("R5 upper bits ignored", rdata, 64'd0);

    // random mix around the live count
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [63:0] d;
      bit [1:0] s;
      r = $urandom;
      s = r[1:0];
      case (s)
        2'd0: d = m_cnt + 64'(($urandom % 40)) - 64'd12;
        2'd1: d = 64'($signed(32'($urandom % 40) - 32'd12));
        2'd2: d = {56'($urandom), 5'd0, 3'($urandom)};
        default: d = 64'($urandom);
      endcase
      cyc(r[4:2] == 3'd0, s, d, r[7:5] != 3'd0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule